// File: doc/BRIEF.md
# Buffered Byte Transmit Serializer

This block turns bytes written over a small register bus into a serial bit stream for a radio baseband. Software writes a byte into a one-entry holding register. While transmission is enabled, the byte moves into a shift register and leaves one bit per bit-rate strobe, most significant bit first. A second byte can wait in the holding register while the first one shifts. That second byte follows the first with no idle bit between them.

Four events are recorded in sticky status flags:
- **empty**: a byte has moved from the holding register into the shift register.
- **done**: the final bit has left and no byte is waiting.
- **overflow**: a byte was written while the holding register was still full.
- **underflow**: transmission was switched on with nothing to send.

Software clears a flag by writing 1 to its bit. A four-bit enable register selects which flags drive the single interrupt line.

Top module: `txser_top`

## Requirements
- R1: After reset the enable register (address 1) and the status register (address 2) both read 0x00, `irq` is low and `tx_bit` is low.
- R2: A read strobe returns the addressed register on `bus_rdata` one clock later. Enable bits 7..4 always read as zero; bits 3..0 hold what was written.
- R3: A byte written to address 0 is shifted out MSB first while `tx_en` is high. The current bit is presented on `tx_bit`, and each `bit_en` pulse advances one bit. `tx_bit` is low whenever no byte is shifting.
- R4: If a byte is waiting when the last bit of the current byte is consumed and `tx_en` is high, that byte's MSB appears on `tx_bit` in the next cycle, with no idle bit.
- R5: Status bit 0 (empty) sets whenever a byte moves from the holding register into the shift register.
- R6: Status bit 1 (done) sets when the last bit of a byte is consumed while no byte is waiting. It stays clear between back-to-back bytes.
- R7: A write to address 0 while the holding register is full sets status bit 2 (overflow). The new byte is discarded and the waiting byte is sent unchanged.
- R8: A rising edge of `tx_en` while nothing is held or shifting sets status bit 3 (underflow).
- R9: Writing to address 2 clears each status bit whose data bit is 1 and leaves the others unchanged.
- R10: `irq` is high exactly when some status bit and the enable bit at the same position are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 2 | Register address: 0 data, 1 enable, 2 status |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe; data appears one cycle later |
| bus_rdata | output | 8 | Registered read data |
| bit_en | input | 1 | Bit-rate strobe that advances the shifter |
| tx_en | input | 1 | Transmit enable; gates loading and underflow detection |
| tx_bit | output | 1 | Serial output |
| irq | output | 1 | Interrupt request |

## Verification
The bench chains two bytes and checks that the second MSB follows the first LSB directly. A design that inserts a gap, or that raises done between the two bytes, fails here. It writes twice without transmitting and then sends, which catches a design that overwrites the held byte or misses the overflow flag. It starts transmission with nothing loaded, which catches a missed underflow flag and any output activity. It also clears a flag that is not set and then clears one that is, and it checks the interrupt line against several enable masks. A wrong clear polarity, or an interrupt that ignores its enable, shows up on these checks.

// File: rtl/txser_pkg.sv
package txser_pkg;
  localparam int NF = 4;
  localparam int F_EMPTY = 0;
  localparam int F_DONE  = 1;
  localparam int F_OVF   = 2;
  localparam int F_UDF   = 3;

  localparam logic [1:0] A_DATA = 2'd0;
  localparam logic [1:0] A_EN   = 2'd1;
  localparam logic [1:0] A_STS  = 2'd2;

  // Sticky flag update: new events win over a simultaneous clear.
  function automatic logic flag_next(input logic cur, input logic clr, input logic ev);
    return (cur & ~clr) | ev;
  endfunction

  function automatic logic irq_of(input logic [NF-1:0] sts, input logic [NF-1:0] en);
    return |(sts & en);
  endfunction
endpackage

// File: rtl/txser_datapath.sv
module txser_datapath #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          data_wr,
  input  logic [DW-1:0] wdata,
  input  logic          bit_en,
  input  logic          tx_en,
  output logic          tx_bit,
  output logic          busy,
  output logic          hold_vld,
  output logic [DW-1:0] hold_q,
  output logic          ld_ev,
  output logic          done_ev,
  output logic          ovf_ev,
  output logic          udf_ev
);
  localparam int CW = (DW > 1) ? $clog2(DW) : 1;
  localparam logic [CW-1:0] LAST = CW'(DW - 1);

  logic [DW-1:0] sh_q;
  logic [CW-1:0] cnt_q;
  logic          tx_en_q;
  logic          shift_last;

  assign shift_last = busy && bit_en && (cnt_q == LAST);
  assign ld_ev      = tx_en && hold_vld && (!busy || shift_last);
  assign done_ev    = shift_last && !hold_vld;
  assign ovf_ev     = data_wr && hold_vld;
  assign udf_ev     = tx_en && !tx_en_q && !hold_vld && !busy;
  assign tx_bit     = busy && sh_q[DW-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_vld <= 1'b0;
      hold_q   <= '0;
      tx_en_q  <= 1'b0;
    end else begin
      tx_en_q <= tx_en;
      if (ld_ev) begin
        hold_vld <= 1'b0;
      end else if (data_wr && !hold_vld) begin
        hold_vld <= 1'b1;
        hold_q   <= wdata;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      cnt_q <= '0;
      busy  <= 1'b0;
    end else if (ld_ev) begin
      sh_q  <= hold_q;
      cnt_q <= '0;
      busy  <= 1'b1;
    end else if (busy && bit_en) begin
      sh_q  <= {sh_q[DW-2:0], 1'b0};
      cnt_q <= cnt_q + 1'b1;
      if (cnt_q == LAST) busy <= 1'b0;
    end
  end
endmodule

// File: rtl/txser_regs.sv
module txser_regs
  import txser_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    addr,
  input  logic [NF-1:0] wlo,
  input  logic          wr,
  input  logic          rd,
  input  logic [NF-1:0] ev,
  output logic [DW-1:0] rdata,
  output logic [NF-1:0] en_q,
  output logic [NF-1:0] sts_q,
  output logic          irq
);
  logic [NF-1:0] clr;
  assign clr = (wr && addr == A_STS) ? wlo : '0;
  assign irq = irq_of(sts_q, en_q);

  for (genvar g = 0; g < NF; g++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sts_q[g] <= 1'b0;
      else        sts_q[g] <= flag_next(sts_q[g], clr[g], ev[g]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= '0;
    else if (wr && addr == A_EN) en_q <= wlo;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata <= '0;
    else if (rd) begin
      case (addr)
        A_EN:    rdata <= {{(DW-NF){1'b0}}, en_q};
        A_STS:   rdata <= {{(DW-NF){1'b0}}, sts_q};
        default: rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/txser_top.sv
module txser_top
  import txser_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    bus_addr,
  input  logic [DW-1:0] bus_wdata,
  input  logic          bus_wr,
  input  logic          bus_rd,
  output logic [DW-1:0] bus_rdata,
  input  logic          bit_en,
  input  logic          tx_en,
  output logic          tx_bit,
  output logic          irq
);
  logic          data_wr;
  logic          busy, hold_vld;
  logic [DW-1:0] hold_q;
  logic          ld_ev, done_ev, ovf_ev, udf_ev;
  logic [NF-1:0] ev, en_q, sts_q;

  assign data_wr = bus_wr && (bus_addr == A_DATA);

  always_comb begin
    ev          = '0;
    ev[F_EMPTY] = ld_ev;
    ev[F_DONE]  = done_ev;
    ev[F_OVF]   = ovf_ev;
    ev[F_UDF]   = udf_ev;
  end

  txser_datapath #(.DW(DW)) u_dp (
    .clk(clk), .rst_n(rst_n), .data_wr(data_wr), .wdata(bus_wdata),
    .bit_en(bit_en), .tx_en(tx_en), .tx_bit(tx_bit), .busy(busy),
    .hold_vld(hold_vld), .hold_q(hold_q), .ld_ev(ld_ev),
    .done_ev(done_ev), .ovf_ev(ovf_ev), .udf_ev(udf_ev)
  );

  txser_regs #(.DW(DW)) u_regs (
    .clk(clk), .rst_n(rst_n), .addr(bus_addr), .wlo(bus_wdata[NF-1:0]),
    .wr(bus_wr), .rd(bus_rd), .ev(ev), .rdata(bus_rdata),
    .en_q(en_q), .sts_q(sts_q), .irq(irq)
  );
endmodule

// File: rtl/txser_chk.sv
module txser_chk
  import txser_pkg::*;
#(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic [1:0]    bus_addr,
  input logic          bus_rd,
  input logic [DW-1:0] bus_rdata,
  input logic          bit_en,
  input logic          tx_en,
  input logic          tx_bit,
  input logic          irq,
  input logic          busy,
  input logic          hold_vld,
  input logic [DW-1:0] hold_q,
  input logic          ld_ev,
  input logic          done_ev,
  input logic          ovf_ev,
  input logic          udf_ev,
  input logic [NF-1:0] en_q,
  input logic [NF-1:0] sts_q
);
  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == A_EN) |=> (bus_rdata[DW-1:NF] == '0)); // R2
  AST_TX_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !tx_bit); // R3
  AST_NO_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && bit_en && tx_en && hold_vld) |=> busy); // R4
  AST_EMPTY_ON_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    ld_ev |=> sts_q[F_EMPTY]); // R5
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_ev |=> (!busy && sts_q[F_DONE])); // R6
  AST_OVF_HOLD_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_ev && !ld_ev) |=> ($stable(hold_q) && sts_q[F_OVF])); // R7
  AST_UDF_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    udf_ev |=> (sts_q[F_UDF] && !busy)); // R8
  AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (en_q != '0)); // R10
endmodule

bind txser_top txser_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
  .bus_rdata(bus_rdata), .bit_en(bit_en), .tx_en(tx_en), .tx_bit(tx_bit),
  .irq(irq), .busy(busy), .hold_vld(hold_vld), .hold_q(hold_q),
  .ld_ev(ld_ev), .done_ev(done_ev), .ovf_ev(ovf_ev), .udf_ev(udf_ev),
  .en_q(en_q), .sts_q(sts_q)
);

// File: tb/sim_txser_top.sv
`timescale 1ns/1ps
module sim_txser_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic       bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_rdata;
  logic       bit_en = 1'b0, tx_en = 1'b0;
  logic       tx_bit, irq;
  int total = 0, bad = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  txser_top u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .bit_en(bit_en), .tx_en(tx_en), .tx_bit(tx_bit), .irq(irq)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bwr(input logic [1:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic brd(input logic [1:0] a, output logic [7:0] d);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  // Checks each bit before the strobe that consumes it.
  task automatic shift_check(input string req, input logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      chk(req, {7'd0, tx_bit}, {7'd0, b[i]});
      bit_en = 1'b1;
      @(negedge clk);
      bit_en = 1'b0;
    end
  endtask

  task automatic t_reset;
    logic [7:0] d;
    brd(2'd1, d); chk("R1 enable reset", d, 8'h00);
    brd(2'd2, d); chk("R1 status reset", d, 8'h00);
    chk("R1 irq reset", {7'd0, irq}, 8'h00);
    chk("R1 tx_bit reset", {7'd0, tx_bit}, 8'h00);
  endtask

  task automatic t_rsvd;
    logic [7:0] d;
    bwr(2'd1, 8'hF5);
    brd(2'd1, d); chk("R2 reserved bits zero", d, 8'h05);
    bwr(2'd1, 8'h00);
  endtask

  task automatic t_single;
    logic [7:0] d;
    bwr(2'd2, 8'hFF);
    tx_en = 1'b0;
    bwr(2'd0, 8'hA5);
    chk("R3 idle before enable", {7'd0, tx_bit}, 8'h00);
    tx_en = 1'b1;
    @(negedge clk);
    brd(2'd2, d); chk("R5 empty on load", d, 8'h01);
    shift_check("R3 msb first", 8'hA5);
    chk("R3 idle after byte", {7'd0, tx_bit}, 8'h00);
    brd(2'd2, d); chk("R6 done after last bit", d, 8'h03);
    tx_en = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_chain;
    logic [7:0] d;
    bwr(2'd2, 8'hFF);
    bwr(2'd0, 8'h3C);
    tx_en = 1'b1;
    @(negedge clk);
    bwr(2'd0, 8'hC3);
    shift_check("R4 first byte", 8'h3C);
    brd(2'd2, d); chk("R6 no done between bytes", d, 8'h01);
    shift_check("R4 second byte no gap", 8'hC3);
    brd(2'd2, d); chk("R6 done after chain", d, 8'h03);
    tx_en = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_overflow;
    logic [7:0] d;
    bwr(2'd2, 8'hFF);
    bwr(2'd0, 8'h81);
    bwr(2'd0, 8'h7E);
    brd(2'd2, d); chk("R7 overflow flag", d, 8'h04);
    tx_en = 1'b1;
    @(negedge clk);
    shift_check("R7 held byte kept", 8'h81);
    chk("R7 dropped byte not sent", {7'd0, tx_bit}, 8'h00);
    brd(2'd2, d); chk("R7 flags after send", d, 8'h07);
    tx_en = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_underflow;
    logic [7:0] d;
    bwr(2'd2, 8'hFF);
    tx_en = 1'b1;
    @(negedge clk);
    @(negedge clk);
    brd(2'd2, d); chk("R8 underflow flag", d, 8'h08);
    chk("R8 no output", {7'd0, tx_bit}, 8'h00);
    tx_en = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_irq_clear;
    logic [7:0] d;
    chk("R10 irq masked", {7'd0, irq}, 8'h00);
    bwr(2'd1, 8'h08);
    chk("R10 irq enabled match", {7'd0, irq}, 8'h01);
    bwr(2'd1, 8'h07);
    chk("R10 irq other enables", {7'd0, irq}, 8'h00);
    bwr(2'd1, 8'h0F);
    bwr(2'd2, 8'h04);
    brd(2'd2, d); chk("R9 clear of unset bit", d, 8'h08);
    chk("R10 irq still set", {7'd0, irq}, 8'h01);
    bwr(2'd2, 8'h08);
    brd(2'd2, d); chk("R9 clear by write one", d, 8'h00);
    chk("R10 irq after clear", {7'd0, irq}, 8'h00);
    bwr(2'd1, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_rsvd();
    t_single();
    t_chain();
    t_overflow();
    t_underflow();
    t_irq_clear();
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule